// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

This block is a watchdog timer that software controls through two 32-bit word registers on a simple memory-mapped register bus. The control/status word holds a run enable, a sticky expiry flag, a choice between a shutdown and a reset as the expiry action, a read-only status bit for hardware disable, and a reload strobe. A second word holds a 16-bit timeout in ticks. A prescaler divides the system clock into ticks. The divide ratio is a parameter, and its default gives a one-second tick on a 100 MHz clock.

Software writes the timeout and then sets the run bit. While the timer runs, software writes the reload strobe often enough to keep the down-counter from reaching zero. If the counter runs out while running, the block sets the expiry flag and drives a one-cycle request: a reset request or a shutdown request, according to the action bit. It then stays idle until it is reloaded or restarted. A strap input can force the hardware-disable state. In that state the timer never counts and never fires.

Top module: `wdog_timer`

## Requirements
- R1: The control word is at byte offset 0x0 and the count word at offset 0x4. Address bits 1:0 are ignored. Any other word offset reads as 0, and writes to it change nothing.
- R2: The count word keeps only data bits 15:0. It reads back zero-extended, and bits 31:16 of a write are ignored. The reset value is 0xFFFF.
- R3: The control word reads back as follows: run in bit 0, expiry flag in bit 1, action in bit 2, hardware-disable status in bit 3. Bits 6:4 read 0, reload bit 7 always reads 0, and bits 31:8 read 0. After reset it reads 0 while the disable strap is low.
- R4: A control write that sets bit 0 while run is clear loads the down-counter from the count word and clears the prescaler. With timeout N (N = 0 acts as 1) and DIV clocks per tick, the expiry request is high in the cycle after the clock edge N*DIV cycles after the write edge.
- R5: A control write with bit 7 set restarts the countdown from the count word and clears the prescaler phase. The next expiry is timed from this write, as in R4.
- R6: On expiry the block drives exactly one cycle of `rst_req` when the action bit is 0, or of `shdn_req` when the action bit is 1. The two are never high together.
- R7: The expiry flag (bit 1) is set on expiry. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged. If an expiry and a clear fall on the same edge, the expiry wins.
- R8: After an expiry the counter stops and no further request is made until a reload or a restart.
- R9: Writing run = 0 stops the countdown, and no request follows. The other control bits take the written values.
- R10: While `hw_disable` is high, bit 3 reads 1 and the timer neither counts nor raises a request.
- R11: During and after reset both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| hw_disable | input | 1 | Strap that makes the timer unusable |
| rst_req | output | 1 | One-cycle reset request on expiry |
| shdn_req | output | 1 | One-cycle shutdown request on expiry |

## Verification
Register reads are combinational, so the bench samples `bus_rdata` in the same low clock phase in which it presents the read. The write that starts or reloads the timer is taken at clock edge E0. The request output is registered, so it is due exactly at the negative edge that follows edge E0 + N*DIV. After every start the bench samples both request lines at each of the following negative edges and expects a pulse at that one point only. The sweeps over timeout and action also cover the quiet period after expiry and the flag readback that follows.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned TMO_W     = 16;
  localparam int unsigned WORD_CTRL = 0;   // byte offset 0x0
  localparam int unsigned WORD_CNT  = 1;   // byte offset 0x4
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_FIRED   = 1;
  localparam int unsigned B_ACTION  = 2;
  localparam int unsigned B_DIS     = 3;
  localparam int unsigned B_RELOAD  = 7;
  localparam logic [TMO_W-1:0] TMO_RST = '1;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = en & ~clr;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] ph_q, ph_d;
      logic          ph_en;

      always_comb begin
        ph_en = clr | en;
        if (clr)             ph_d = '0;
        else if (ph_q == LAST) ph_d = '0;
        else                 ph_d = ph_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ph_q <= '0;
        else if (ph_en)  ph_q <= ph_d;
      end

      assign tick = en & ~clr & (ph_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             hw_disable,
  input  logic             action,
  input  logic             tick,
  input  logic [TMO_W-1:0] tmo,
  output logic             counting,
  output logic             expire,
  output logic             rst_req,
  output logic             shdn_req
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             idle_q, idle_d;
  logic             cnt_en;
  logic             rst_d, shdn_d;

  assign counting = run & ~hw_disable & ~idle_q;
  assign expire   = counting & tick & ~start & (cnt_q <= TMO_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    idle_d = idle_q;
    cnt_en = 1'b0;
    if (start) begin
      cnt_d  = tmo;
      idle_d = 1'b0;
      cnt_en = 1'b1;
    end else if (expire) begin
      cnt_d  = '0;
      idle_d = 1'b1;
      cnt_en = 1'b1;
    end else if (counting & tick) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
    rst_d  = expire & ~action;
    shdn_d = expire &  action;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= TMO_RST;
      idle_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      shdn_req <= 1'b0;
    end else begin
      rst_req  <= rst_d;
      shdn_req <= shdn_d;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_disable,
  input  logic              expire,
  output logic              run,
  output logic              action,
  output logic              fired,
  output logic [TMO_W-1:0]  tmo,
  output logic              start
);
  localparam int unsigned SEL_W = ADDR_W - 2;

  logic sel_ctrl, sel_cnt, wr_ctrl, wr_cnt, rd;
  logic run_d, action_d, fired_d, fired_en;
  logic [TMO_W-1:0] tmo_d;

  assign sel_ctrl = (bus_addr[ADDR_W-1:2] == SEL_W'(WORD_CTRL));
  assign sel_cnt  = (bus_addr[ADDR_W-1:2] == SEL_W'(WORD_CNT));
  assign wr_ctrl  = bus_valid & bus_we & sel_ctrl;
  assign wr_cnt   = bus_valid & bus_we & sel_cnt;
  assign rd       = bus_valid & ~bus_we;

  always_comb begin
    run_d    = bus_wdata[B_RUN];
    action_d = bus_wdata[B_ACTION];
    tmo_d    = bus_wdata[TMO_W-1:0];
    fired_d  = (fired & ~(wr_ctrl & bus_wdata[B_FIRED])) | expire;
    fired_en = wr_ctrl | expire;
    start    = wr_ctrl & (bus_wdata[B_RELOAD] | (bus_wdata[B_RUN] & ~run));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      action <= 1'b0;
    end else if (wr_ctrl) begin
      run    <= run_d;
      action <= action_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fired <= 1'b0;
    else if (fired_en) fired <= fired_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo <= TMO_RST;
    else if (wr_cnt) tmo <= tmo_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd && sel_ctrl) begin
      bus_rdata[B_RUN]    = run;
      bus_rdata[B_FIRED]  = fired;
      bus_rdata[B_ACTION] = action;
      bus_rdata[B_DIS]    = hw_disable;
    end else if (rd && sel_cnt) begin
      bus_rdata[TMO_W-1:0] = tmo;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned TICK_DIV = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_disable,
  output logic              rst_req,
  output logic              shdn_req
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic             ctl_run, ctl_action, ctl_fired, start;
  logic [TMO_W-1:0] tmo;
  logic             counting, tick, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_disable(hw_disable), .expire(expire),
    .run(ctl_run), .action(ctl_action), .fired(ctl_fired),
    .tmo(tmo), .start(start)
  );

  wdog_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .en(counting), .clr(start), .tick(tick)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_int_n), .start(start), .run(ctl_run),
    .hw_disable(hw_disable), .action(ctl_action), .tick(tick), .tmo(tmo),
    .counting(counting), .expire(expire), .rst_req(rst_req), .shdn_req(shdn_req)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_disable,
  input logic run,
  input logic fired,
  input logic rst_req,
  input logic shdn_req
);
  // R6
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && shdn_req));
  // R6
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R6
  shdn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_req |=> !shdn_req);
  // R7
  fired_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || shdn_req) |-> fired);
  // R9
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(rst_req || shdn_req));
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_disable |=> !(rst_req || shdn_req));
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_disable(hw_disable), .run(ctl_run),
  .fired(ctl_fired), .rst_req(rst_req), .shdn_req(shdn_req)
);

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  localparam int DIV = 4;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          hw_disable = 1'b0;
  logic          rst_req, shdn_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_timer #(.ADDR_W(AW), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_disable(hw_disable), .rst_req(rst_req), .shdn_req(shdn_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  // Sample both requests at negedges k = 1..last after a start edge;
  // a pulse is expected only at k == due (due = 0 means none).
  task automatic watch(input string req, input int due, input int last, input logic act);
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k == due) check(req, {30'b0, rst_req, shdn_req}, act ? 32'd1 : 32'd2);
      else          check(req, {30'b0, rst_req, shdn_req}, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R11 outputs low during reset
    check("R11", {30'b0, rst_req, shdn_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", {30'b0, rst_req, shdn_req}, 0);
    // R3 control reset value, R2 count reset value
    rd(4'h0, v); check("R3", v, 32'h0);
    rd(4'h4, v); check("R2", v, 32'h0000_FFFF);
    // R2 upper bits dropped
    wr(4'h4, 32'hABCD_0123); rd(4'h4, v); check("R2", v, 32'h0000_0123);
    // R1 unmapped offsets
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); check("R1", v, 0);
    rd(4'hC, v); check("R1", v, 0);
    rd(4'h4, v); check("R1", v, 32'h0000_0123);
    rd(4'h6, v); check("R1", v, 32'h0000_0123);
    // R3 reserved and reload read 0 (run stays 0: reload alone keeps it stopped)
    wr(4'h0, 32'hFFFF_FFF4); rd(4'h0, v); check("R3", v, 32'h4);
    watch("R9", 0, 3 * DIV, 1'b0);
    wr(4'h0, 32'h2);

    // R4 R6 R8 R7 sweep over timeout and action
    for (int act = 0; act < 2; act++) begin
      for (int n = 0; n < 6; n++) begin
        int due;
        due = (n == 0 ? 1 : n) * DIV;
        wr(4'h4, 32'(n));
        wr(4'h0, 32'h1 | (act << 2));
        watch("R4 R6 R8", due, due + 3 * DIV, act[0]);
        rd(4'h0, v); check("R7", v, 32'h3 | (act << 2));
        wr(4'h0, 32'h2);
        rd(4'h0, v); check("R7", v, 0);
      end
    end

    // R7 writing 0 to the flag leaves it set
    wr(4'h4, 32'd1);
    wr(4'h0, 32'h1);
    watch("R7", DIV, DIV + 1, 1'b0);
    wr(4'h0, 32'h1); rd(4'h0, v); check("R7", v, 32'h3);
    wr(4'h0, 32'h2);

    // R5 reload restarts and clears the prescaler phase
    wr(4'h4, 32'd3);
    wr(4'h0, 32'h5);
    watch("R5", 0, DIV + 2, 1'b1);
    wr(4'h0, 32'h85);
    watch("R5", 3 * DIV, 3 * DIV + 2 * DIV, 1'b1);
    // R8 reload after expiry re-arms
    wr(4'h0, 32'h87);
    watch("R8", 3 * DIV, 3 * DIV + 2, 1'b1);
    wr(4'h0, 32'h2);

    // R9 clearing run stops the count, other bits take written values
    wr(4'h4, 32'd2);
    wr(4'h0, 32'h1);
    watch("R9", 0, DIV, 1'b0);
    wr(4'h0, 32'h4);
    rd(4'h0, v); check("R9", v, 32'h4);
    watch("R9", 0, 4 * DIV, 1'b0);
    wr(4'h0, 32'h5);
    watch("R4", 2 * DIV, 2 * DIV + 2, 1'b1);
    wr(4'h0, 32'h2);

    // R10 hardware disable
    hw_disable = 1'b1;
    wr(4'h4, 32'd1);
    wr(4'h0, 32'h1);
    watch("R10", 0, 4 * DIV, 1'b0);
    rd(4'h0, v); check("R10", v, 32'h9);
    wr(4'h0, 32'h81);
    watch("R10", 0, 3 * DIV, 1'b0);
    wr(4'h0, 32'h2);
    hw_disable = 1'b0;
    rd(4'h0, v); check("R10", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule